// File: doc/BRIEF.md
# Register Rename Tag Scoreboard

The scoreboard keeps, for every architectural register, a pending flag and the reorder-buffer tag of the youngest in-flight instruction that will write it. Dependent instructions look up their two source registers. A source that is not pending is read from the register file. A pending source is read from the reorder-buffer entry named by the returned tag as soon as that entry's functional unit has finished, without waiting for commit to write the register file. This removes the cycle that is otherwise lost on every read-after-write hazard.

Every reorder-buffer entry passes through the allocation port in program order. An instruction with no destination, such as a branch, allocates to register 0, which is never marked pending. The allocation port is a valid/ready stream. A transfer happens on a rising edge where `alloc_valid` and `alloc_ready` are both high. The scoreboard drops `alloc_ready` when the history ring is full, in the cycle a rollback is requested, and while a rollback is in progress. The source may hold or change its request while `alloc_ready` is low. Each accepted allocation pushes a history record that holds the previous flag and tag of its destination. Commit retires the oldest record. A branch-mispredict rollback walks the records from the youngest back to the branch's own entry and restores each saved mapping. The commit and rollback pins are plain control strobes.

Top module: `rename_scoreboard`

## Requirements
- R1: After reset every register reads not pending, `rb_busy` is low and `alloc_ready` is high.
- R2: An accepted allocation to register r (r not 0) makes r read pending with `alloc_tag` from the next cycle.
- R3: Source lookups are combinational on the stored state, so a lookup in the same cycle as an allocation or commit returns the mapping from before that edge.
- R4: Register 0 always reads not pending, including after an allocation to it.
- R5: A commit clears a register's pending flag only when that register's stored tag equals `commit_tag`. A register that has been remapped to a younger tag stays pending.
- R6: Commits arrive in allocation order and carry the tag of the oldest outstanding allocation. No commit is presented while `rb_busy` is high.
- R7: `alloc_ready` is low while the history holds 32 records, and an allocation offered then has no effect.
- R8: A rollback request with branch tag b sets `rb_busy` from the next cycle. The block then undoes one record per cycle, youngest first, until the youngest remaining record carries tag b. With k records to undo, `rb_busy` stays high for k+1 cycles, and afterwards each affected register holds the flag and tag it had before the undone allocations.
- R9: If the producer saved in a history record commits before that record is undone, the rollback restores the register as not pending.
- R10: `alloc_ready` is low in the cycle `rb_valid` is high and in every cycle `rb_busy` is high, and the history never grows during a rollback.
- R11: A source that is not pending reports tag 0.
- R12: A commit and an allocation that touch the same register on one edge leave the register pending with the new allocation's tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation request valid |
| alloc_ready | output | 1 | Allocation can be accepted |
| alloc_reg | input | 5 | Destination register (0 for none) |
| alloc_tag | input | 5 | Reorder-buffer tag of the allocating instruction |
| commit_valid | input | 1 | Oldest outstanding entry commits |
| commit_tag | input | 5 | Tag of the committing entry |
| rb_valid | input | 1 | Branch-mispredict rollback request |
| rb_tag | input | 5 | Tag of the mispredicted branch |
| rb_busy | output | 1 | Rollback in progress; lookups are not yet final |
| src0_reg | input | 5 | First source register |
| src0_pending | output | 1 | First source awaits a producer |
| src0_tag | output | 5 | Producer tag for the first source |
| src1_reg | input | 5 | Second source register |
| src1_pending | output | 1 | Second source awaits a producer |
| src1_tag | output | 5 | Producer tag for the second source |

## Verification
The hardest situation to reach is a rollback that restores a mapping whose producer has already committed after it was superseded. Reaching it needs a register written twice around a branch, with the first write committing before the mispredict arrives. A directed sequence builds exactly that order. A long pseudo-random phase then mixes allocations to a handful of registers, in-order commits and rollbacks to randomly chosen in-flight branches. This phase also presses allocations against a full history and against an active rollback, and a behavioural queue model is compared with the ports on every clock.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int NUM_REGS   = 32;
  localparam int ROB_DEPTH  = 32;
  localparam int HIST_DEPTH = ROB_DEPTH;
  localparam int REG_W      = $clog2(NUM_REGS);
  localparam int TAG_W      = $clog2(ROB_DEPTH);
  localparam int HPTR_W     = $clog2(HIST_DEPTH);
  localparam int HCNT_W     = $clog2(HIST_DEPTH + 1);
  localparam int NUM_SRC    = 2;

  typedef logic [REG_W-1:0] reg_idx_t;
  typedef logic [TAG_W-1:0] rob_tag_t;

  typedef struct packed {
    reg_idx_t dst;
    rob_tag_t tag;
    logic     prev_pend;
    rob_tag_t prev_tag;
  } hist_entry_t;
endpackage

// File: rtl/sb_rename_map.sv
module sb_rename_map
  import sb_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    alloc_we,
  input  reg_idx_t                alloc_reg,
  input  rob_tag_t                alloc_tag,
  input  logic                    commit_we,
  input  rob_tag_t                commit_tag,
  input  logic                    rest_we,
  input  reg_idx_t                rest_reg,
  input  logic                    rest_pend,
  input  rob_tag_t                rest_tag,
  output logic [NUM_REGS-1:0]     pend_vec,
  output rob_tag_t [NUM_REGS-1:0] tag_vec
);
  // One pending flag and producer tag per architectural register.
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic WRITABLE = (g != 0);
    logic     p_q;
    rob_tag_t t_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        p_q <= 1'b0;
        t_q <= '0;
      end else if (WRITABLE && rest_we && rest_reg == reg_idx_t'(g)) begin
        p_q <= rest_pend;
        t_q <= rest_tag;
      end else if (WRITABLE && alloc_we && alloc_reg == reg_idx_t'(g)) begin
        p_q <= 1'b1;
        t_q <= alloc_tag;
      end else if (commit_we && p_q && t_q == commit_tag) begin
        p_q <= 1'b0;
      end
    end

    assign pend_vec[g] = p_q;
    assign tag_vec[g]  = t_q;

    // R5
    remapped_stays_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_we && !rest_we && p_q && t_q != commit_tag) |=> p_q);
  end
endmodule

// File: rtl/sb_history.sv
module sb_history
  import sb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push,
  input  hist_entry_t push_ent,
  input  logic        pop_old,
  input  rob_tag_t    old_tag,
  input  logic        pop_young,
  output hist_entry_t young_ent,
  output logic [HCNT_W-1:0] count,
  output logic        full
);
  hist_entry_t        mem [HIST_DEPTH];
  logic [HPTR_W-1:0]  head_q, tail_q;
  logic [HCNT_W-1:0]  cnt_q;
  logic [HPTR_W-1:0]  young_idx;

  function automatic logic [HPTR_W-1:0] wrap_inc(input logic [HPTR_W-1:0] p);
    return (p == HPTR_W'(HIST_DEPTH - 1)) ? '0 : p + HPTR_W'(1);
  endfunction

  function automatic logic [HPTR_W-1:0] wrap_dec(input logic [HPTR_W-1:0] p);
    return (p == '0) ? HPTR_W'(HIST_DEPTH - 1) : p - HPTR_W'(1);
  endfunction

  assign young_idx = wrap_dec(tail_q);
  assign young_ent = mem[young_idx];
  assign count     = cnt_q;
  assign full      = (cnt_q == HCNT_W'(HIST_DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      for (int i = 0; i < HIST_DEPTH; i++) mem[i] <= '0;
    end else begin
      // A retiring producer can no longer be restored as pending.
      if (pop_old) begin
        for (int i = 0; i < HIST_DEPTH; i++)
          if (mem[i].prev_tag == old_tag) mem[i].prev_pend <= 1'b0;
        head_q <= wrap_inc(head_q);
      end
      if (push) begin
        mem[tail_q] <= push_ent;
        tail_q      <= wrap_inc(tail_q);
      end else if (pop_young) begin
        tail_q <= young_idx;
      end
      cnt_q <= cnt_q + HCNT_W'(push) - HCNT_W'(pop_old) - HCNT_W'(pop_young);
    end
  end

  // R7
  hist_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q < HCNT_W'(HIST_DEPTH)));

  // R6
  commit_in_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_old |-> (cnt_q != '0 && mem[head_q].tag == old_tag));

  // R8
  undo_needs_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_young |-> (cnt_q != '0 && !push && !pop_old));
endmodule

// File: rtl/sb_src_port.sv
module sb_src_port
  import sb_pkg::*;
(
  input  logic [NUM_REGS-1:0]     pend_vec,
  input  rob_tag_t [NUM_REGS-1:0] tag_vec,
  input  reg_idx_t                sel,
  output logic                    pend,
  output rob_tag_t                tag
);
  always_comb begin
    pend = pend_vec[sel];
    tag  = pend ? tag_vec[sel] : '0;
  end
endmodule

// File: rtl/rename_scoreboard.sv
module rename_scoreboard
  import sb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_valid,
  output logic             alloc_ready,
  input  logic [REG_W-1:0] alloc_reg,
  input  logic [TAG_W-1:0] alloc_tag,
  input  logic             commit_valid,
  input  logic [TAG_W-1:0] commit_tag,
  input  logic             rb_valid,
  input  logic [TAG_W-1:0] rb_tag,
  output logic             rb_busy,
  input  logic [REG_W-1:0] src0_reg,
  output logic             src0_pending,
  output logic [TAG_W-1:0] src0_tag,
  input  logic [REG_W-1:0] src1_reg,
  output logic             src1_pending,
  output logic [TAG_W-1:0] src1_tag
);
  logic [NUM_REGS-1:0]     map_pend;
  rob_tag_t [NUM_REGS-1:0] map_tag;
  hist_entry_t             young_ent, push_ent;
  logic [HCNT_W-1:0]       hist_cnt;
  logic                    hist_full;
  logic                    busy_q;
  rob_tag_t                target_q;
  logic                    undo_step, alloc_fire, commit_go;

  // Rollback walker: one history record per cycle, youngest first.
  assign undo_step = busy_q && hist_cnt != '0 && young_ent.tag != target_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      target_q <= '0;
    end else if (busy_q) begin
      if (!undo_step) busy_q <= 1'b0;
    end else if (rb_valid) begin
      busy_q   <= 1'b1;
      target_q <= rb_tag;
    end
  end

  assign rb_busy     = busy_q;
  assign alloc_ready = !busy_q && !rb_valid && !hist_full;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign commit_go   = commit_valid && !busy_q;

  // Saved mapping reflects a commit retiring the same producer on this edge.
  always_comb begin
    push_ent.dst       = alloc_reg;
    push_ent.tag       = alloc_tag;
    push_ent.prev_tag  = map_tag[alloc_reg];
    push_ent.prev_pend = map_pend[alloc_reg] &&
                         !(commit_go && map_tag[alloc_reg] == commit_tag);
  end

  sb_rename_map u_map (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_we   (alloc_fire),
    .alloc_reg  (alloc_reg),
    .alloc_tag  (alloc_tag),
    .commit_we  (commit_go),
    .commit_tag (commit_tag),
    .rest_we    (undo_step),
    .rest_reg   (young_ent.dst),
    .rest_pend  (young_ent.prev_pend),
    .rest_tag   (young_ent.prev_tag),
    .pend_vec   (map_pend),
    .tag_vec    (map_tag)
  );

  sb_history u_hist (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (alloc_fire),
    .push_ent  (push_ent),
    .pop_old   (commit_go),
    .old_tag   (commit_tag),
    .pop_young (undo_step),
    .young_ent (young_ent),
    .count     (hist_cnt),
    .full      (hist_full)
  );

  reg_idx_t src_sel [NUM_SRC];
  logic     src_p   [NUM_SRC];
  rob_tag_t src_t   [NUM_SRC];

  assign src_sel[0] = src0_reg;
  assign src_sel[1] = src1_reg;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    sb_src_port u_port (
      .pend_vec (map_pend),
      .tag_vec  (map_tag),
      .sel      (src_sel[s]),
      .pend     (src_p[s]),
      .tag      (src_t[s])
    );
  end

  assign src0_pending = src_p[0];
  assign src0_tag     = src_t[0];
  assign src1_pending = src_p[1];
  assign src1_tag     = src_t[1];

  // R2
  alloc_sets_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_fire && alloc_reg != '0) |=>
      (map_pend[$past(alloc_reg)] && map_tag[$past(alloc_reg)] == $past(alloc_tag)));

  // R4
  zero_reg_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src0_reg == '0) |-> !src0_pending);

  // R6
  no_commit_in_rollback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !commit_valid);

  // R8
  undo_shrinks_history_chk: assert property (@(posedge clk) disable iff (!rst_n)
    undo_step |=> (hist_cnt == $past(hist_cnt) - HCNT_W'(1)));

  // R10
  hist_no_growth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> (hist_cnt <= $past(hist_cnt)));
endmodule

// File: tb/rename_scoreboard_tb.sv
`timescale 1ns/1ps
module rename_scoreboard_tb;
  import sb_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_valid = 1'b0, commit_valid = 1'b0, rb_valid = 1'b0;
  logic alloc_ready, rb_busy, src0_pending, src1_pending;
  logic [REG_W-1:0] alloc_reg = '0, src0_reg = '0, src1_reg = '0;
  logic [TAG_W-1:0] alloc_tag = '0, commit_tag = '0, rb_tag = '0;
  logic [TAG_W-1:0] src0_tag, src1_tag;

  always #2 clk = ~clk;

  rename_scoreboard u_dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_reg(alloc_reg), .alloc_tag(alloc_tag),
    .commit_valid(commit_valid), .commit_tag(commit_tag),
    .rb_valid(rb_valid), .rb_tag(rb_tag), .rb_busy(rb_busy),
    .src0_reg(src0_reg), .src0_pending(src0_pending), .src0_tag(src0_tag),
    .src1_reg(src1_reg), .src1_pending(src1_pending), .src1_tag(src1_tag)
  );

  typedef struct { int r; int t; bit pp; int pt; } rec_t;
  rec_t q[$];
  bit  mp [NUM_REGS];
  int  mt [NUM_REGS];
  int  next_tag = 0;
  int  busy_cnt = 0;
  int  checks = 0, fails = 0;
  bit  done = 1'b0;
  int unsigned seed = 32'h1234_5678;

  function automatic int rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'(seed >> 16);
  endfunction

  task automatic check(input string what, input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // One clock of stimulus, comparison and model update.
  task automatic cyc(input bit av, input int areg, input bit cv, input bit rbv,
                     input int rbt, input int s0, input int s1, input string req);
    bit exp_ready, do_commit;
    int k;
    @(negedge clk);
    do_commit    = cv && q.size() > 0 && busy_cnt == 0 && !rbv;
    alloc_valid  = av;
    alloc_reg    = REG_W'(areg);
    alloc_tag    = TAG_W'(next_tag);
    commit_valid = do_commit;
    commit_tag   = do_commit ? TAG_W'(q[0].t) : '0;
    rb_valid     = rbv;
    rb_tag       = TAG_W'(rbt);
    src0_reg     = REG_W'(s0);
    src1_reg     = REG_W'(s1);
    #1;
    exp_ready = (busy_cnt == 0) && !rbv && (q.size() < HIST_DEPTH);
    check("alloc_ready", int'(alloc_ready), int'(exp_ready), req);
    check("rb_busy", int'(rb_busy), int'(busy_cnt > 0), req);
    if (busy_cnt == 0) begin
      check("src0_pending", int'(src0_pending), int'(mp[s0]), req);
      check("src0_tag", int'(src0_tag), mp[s0] ? mt[s0] : 0, req);
      check("src1_pending", int'(src1_pending), int'(mp[s1]), req);
      check("src1_tag", int'(src1_tag), mp[s1] ? mt[s1] : 0, req);
    end
    @(posedge clk);
    if (busy_cnt > 0) begin
      busy_cnt--;
    end else if (rbv) begin
      k = 0;
      while (q.size() > 0 && q[$].t != rbt) begin
        rec_t e = q.pop_back();
        if (e.r != 0) begin mp[e.r] = e.pp; mt[e.r] = e.pt; end
        k++;
      end
      busy_cnt = k + 1;
      next_tag = (rbt + 1) % ROB_DEPTH;
    end else begin
      if (do_commit) begin
        int ct = q[0].t;
        for (int r = 0; r < NUM_REGS; r++) if (mp[r] && mt[r] == ct) mp[r] = 1'b0;
        foreach (q[i]) if (q[i].pt == ct) q[i].pp = 1'b0;
        void'(q.pop_front());
      end
      if (av && exp_ready) begin
        rec_t n;
        n.r = areg; n.t = next_tag; n.pp = mp[areg]; n.pt = mt[areg];
        q.push_back(n);
        if (areg != 0) begin mp[areg] = 1'b1; mt[areg] = next_tag; end
        next_tag = (next_tag + 1) % ROB_DEPTH;
      end
    end
  endtask

  task automatic idle(input int s0, input int s1, input string req);
    cyc(1'b0, 0, 1'b0, 1'b0, 0, s0, s1, req);
  endtask

  task automatic drain();
    while (q.size() > 0) cyc(1'b0, 0, 1'b1, 1'b0, 0, q[0].r, 0, "R6");
  endtask

  task automatic wait_rb(input int s0, input int s1, input string req);
    while (busy_cnt > 0) cyc(1'b1, 4, 1'b0, 1'b0, 0, s0, s1, req);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int br;
    for (int r = 0; r < NUM_REGS; r++) begin mp[r] = 1'b0; mt[r] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    idle(5, 31, "R1");
    // R3: lookup of r3 while it is allocated sees the old state
    cyc(1'b1, 3, 1'b0, 1'b0, 0, 3, 3, "R3");
    // R2: pending with tag 0 next cycle
    idle(3, 1, "R2");
    check("r3 tag", int'(src0_tag), 0, "R2");
    // R4: allocation to register 0
    cyc(1'b1, 0, 1'b0, 1'b0, 0, 0, 3, "R4");
    idle(0, 3, "R4");
    check("r0 pending", int'(src0_pending), 0, "R4");
    // R5: rename r3 then commit the older producer
    cyc(1'b1, 3, 1'b0, 1'b0, 0, 3, 0, "R3");
    cyc(1'b0, 0, 1'b1, 1'b0, 0, 3, 0, "R5");
    idle(3, 0, "R5");
    check("r3 still pending", int'(src0_pending), 1, "R5");
    // R12: commit of r3's producer with a new r3 allocation on one edge
    cyc(1'b0, 0, 1'b1, 1'b0, 0, 3, 0, "R6");
    cyc(1'b1, 3, 1'b1, 1'b0, 0, 3, 0, "R12");
    idle(3, 0, "R12");
    check("r3 pending after alloc+commit", int'(src0_pending), 1, "R12");
    // R11: commit the last producer; not pending reports tag 0
    drain();
    idle(3, 3, "R11");
    check("r3 tag when idle", int'(src0_tag), 0, "R11");

    // R9: superseded producer commits before rollback
    cyc(1'b1, 5, 1'b0, 1'b0, 0, 5, 0, "R9");
    br = next_tag;
    cyc(1'b1, 0, 1'b0, 1'b0, 0, 5, 0, "R9");
    cyc(1'b1, 5, 1'b0, 1'b0, 0, 5, 0, "R9");
    cyc(1'b0, 0, 1'b1, 1'b0, 0, 5, 0, "R9");
    cyc(1'b0, 0, 1'b0, 1'b1, br, 5, 0, "R9");
    wait_rb(5, 0, "R10");
    idle(5, 0, "R9");
    check("r5 restored not pending", int'(src0_pending), 0, "R9");
    drain();

    // R8: undo three records back to a branch
    cyc(1'b1, 7, 1'b0, 1'b0, 0, 7, 8, "R8");
    br = next_tag;
    cyc(1'b1, 0, 1'b0, 1'b0, 0, 7, 8, "R8");
    cyc(1'b1, 7, 1'b0, 1'b0, 0, 7, 8, "R8");
    cyc(1'b1, 8, 1'b0, 1'b0, 0, 7, 8, "R8");
    cyc(1'b1, 7, 1'b0, 1'b0, 0, 7, 8, "R8");
    cyc(1'b1, 9, 1'b0, 1'b1, br, 7, 8, "R10");
    check("busy cycles expected", busy_cnt, 4, "R8");
    wait_rb(7, 8, "R10");
    idle(7, 8, "R8");
    check("r7 pending", int'(src0_pending), 1, "R8");
    check("r7 tag", int'(src0_tag), (br + ROB_DEPTH - 1) % ROB_DEPTH, "R8");
    check("r8 pending", int'(src1_pending), 0, "R8");
    drain();

    // R7: fill the history, then offer one more allocation
    for (int i = 0; i < HIST_DEPTH; i++) cyc(1'b1, 1 + (i % 6), 1'b0, 1'b0, 0, 1, 2, "R7");
    cyc(1'b1, 9, 1'b0, 1'b0, 0, 9, 1, "R7");
    idle(9, 1, "R7");
    check("r9 untouched when full", int'(src0_pending), 0, "R7");
    drain();

    // Random mix of allocation, commit and rollback
    for (int n = 0; n < 6000; n++) begin
      int sel = rnd() % 16;
      if (busy_cnt > 0)
        cyc(rnd() % 2 == 0, rnd() % 6, 1'b0, 1'b0, 0, rnd() % 6, rnd() % 6, "R10");
      else if (sel == 0 && q.size() > 0)
        cyc(1'b1, rnd() % 6, 1'b0, 1'b1, q[rnd() % q.size()].t, rnd() % 6, rnd() % 6, "R8");
      else
        cyc(rnd() % 4 != 0, rnd() % 6, (rnd() % 3 == 0), 1'b0, 0,
            rnd() % 6, rnd() % 6, "R3");
    end
    wait_rb(0, 1, "R10");
    drain();
    idle(1, 2, "R5");
    summary();
  end
endmodule